// File: doc/BRIEF.md
# Redistributor Group Power Controller

This block is the hardware side of power gating for a group of interrupt redistributor frames. Every frame has one 32-bit power register, reached through a shared register port that carries a frame index and a byte offset. Software turns a frame on or off by writing that register's frame power-down bit. The group as a whole shuts down when its last running frame is switched off. It comes back up when any frame asks for power. Power switches are not modelled; each group transition is a timed change of state that takes a fixed number of cycles, set by a parameter.

Two group bits sit in every frame's power register. One holds the requested group power-down state and the other holds the observed state. While they differ, a group transition is in flight. During that time a write to the frame power-down bit is dropped, and software must poll and retry. A power-on request made while the group is shutting down cancels the shutdown.

Top module: `rdgp_ctrl`

## Requirements
- R1: After reset every frame power-down bit is 1 and every gating bit is 0. Both group bits are 1, so the power register of every frame reads 0x0000000D, grp_off is 1, grp_busy is 0 and frame_on is all zeros.
- R2: A read (acc_en=1, acc_wr=0) returns the power register of frame acc_frame in the same cycle when acc_offset is 0x24. The layout is bit 0 frame power-down, bit 1 gating, bit 2 group power-down request, bit 3 group power-off observed. A read of any other offset returns 0.
- R3: Bits 31:4 always read 0, and writes to them have no effect. A write to any offset other than 0x24 changes nothing.
- R4: A write to offset 0x24 loads bit 1 into the frame's gating bit at the write edge, whether or not a group transition is in flight.
- R5: When the group is off and idle, a write of bit 0 = 0 clears the group request bit (bit 2) at the write edge and leaves the frame's bit 0 at 1.
- R6: The observed bit (bit 3) takes the value of the request bit exactly TRANS_CYCLES clock edges after the edge that started the transition, and not earlier.
- R7: When the group is on and idle, a write of bit 0 sets that frame's power-down bit to the written value at the write edge.
- R8: Writing 1 to bit 0 of the only frame that is on, while the group is on and idle, sets the frame bit and the group request bit together at the write edge. Switching off a frame while another frame is on leaves the group on.
- R9: While bits 2 and 3 differ, writes to bit 0 of any frame leave every frame's power-down bit unchanged.
- R10: During a shutdown (bit 2 = 1, bit 3 = 0), a write of bit 0 = 0 to any frame returns bit 2 to 0 at the write edge. Bit 3 stays 0, so the group is on and idle again.
- R11: grp_off is 1 exactly when both group bits are 1. grp_busy is 1 exactly when they differ. frame_on[i] is the inverse of frame i's power-down bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_frame | input | FRAME_W | Frame index of the access |
| acc_offset | input | OFS_W | Byte offset within the frame's register space |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational |
| grp_off | output | 1 | Group fully powered off |
| grp_busy | output | 1 | Group transition in flight |
| frame_on | output | NUM_FRAMES | Per-frame powered-on flags |

## Verification
Read data is combinational, so it is due in the same cycle as the read. Every register field that a write changes is due right after the write edge. The observed group bit is due exactly TRANS_CYCLES edges after the edge that starts a transition. The bench drives inputs on the falling edge and compares every output with a behavioural model 1 ns after each falling edge. Its directed checks count edges from the write edge and sample both one cycle before and at the edge where bit 3 is due to change.

// File: rtl/rdgp_pkg.sv
package rdgp_pkg;
  localparam int unsigned PWR_REG_OFS  = 'h24;
  localparam int unsigned BIT_FRAME_PD = 0;
  localparam int unsigned BIT_GATE     = 1;
  localparam int unsigned BIT_GRP_PD   = 2;
  localparam int unsigned BIT_GRP_PO   = 3;

  typedef struct packed {
    logic pd;
    logic gate;
  } pwr_wr_t;
endpackage

// File: rtl/rdgp_reg_decode.sv
module rdgp_reg_decode
  import rdgp_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 4,
  parameter int unsigned FRAME_W    = 2,
  parameter int unsigned OFS_W      = 16
) (
  input  logic                  acc_en,
  input  logic                  acc_wr,
  input  logic [FRAME_W-1:0]    acc_frame,
  input  logic [OFS_W-1:0]      acc_offset,
  input  logic [1:0]            acc_wbits,
  input  logic [NUM_FRAMES-1:0] frame_pd,
  input  logic [NUM_FRAMES-1:0] frame_gate,
  input  logic                  grp_pd,
  input  logic                  grp_po,
  output logic [NUM_FRAMES-1:0] wr_sel,
  output pwr_wr_t               wr_fields,
  output logic [31:0]           acc_rdata
);
  logic frame_ok;
  logic reg_hit;

  assign frame_ok = int'(acc_frame) < NUM_FRAMES;
  assign reg_hit  = acc_en && frame_ok && (acc_offset == OFS_W'(PWR_REG_OFS));

  assign wr_fields.pd   = acc_wbits[BIT_FRAME_PD];
  assign wr_fields.gate = acc_wbits[BIT_GATE];

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_sel
    assign wr_sel[g] = reg_hit && acc_wr && (acc_frame == FRAME_W'(g));
  end

  always_comb begin
    acc_rdata = '0;
    if (reg_hit && !acc_wr) begin
      acc_rdata[BIT_FRAME_PD] = frame_pd[acc_frame];
      acc_rdata[BIT_GATE]     = frame_gate[acc_frame];
      acc_rdata[BIT_GRP_PD]   = grp_pd;
      acc_rdata[BIT_GRP_PO]   = grp_po;
    end
  end
endmodule

// File: rtl/rdgp_frame_bank.sv
module rdgp_frame_bank
  import rdgp_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FRAMES-1:0] wr_sel,
  input  pwr_wr_t               wr_fields,
  input  logic                  pd_wr_ok,
  output logic [NUM_FRAMES-1:0] frame_pd,
  output logic [NUM_FRAMES-1:0] frame_gate,
  output logic                  lone_off_req
);
  logic [NUM_FRAMES-1:0] lone_on;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic pd_en;
    logic gate_en;

    assign pd_en      = wr_sel[g] && pd_wr_ok;
    assign gate_en    = wr_sel[g];
    assign lone_on[g] = !frame_pd[g] && (&(frame_pd | (NUM_FRAMES'(1) << g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frame_pd[g]   <= 1'b1;
        frame_gate[g] <= 1'b0;
      end else begin
        if (pd_en)   frame_pd[g]   <= wr_fields.pd;
        if (gate_en) frame_gate[g] <= wr_fields.gate;
      end
    end
  end

  assign lone_off_req = wr_fields.pd && |(wr_sel & lone_on);
endmodule

// File: rtl/rdgp_group_seq.sv
module rdgp_group_seq #(
  parameter int unsigned TRANS_CYCLES = 6,
  parameter int unsigned CNT_W        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_req,
  input  logic sleep_req,
  output logic grp_pd,
  output logic grp_po,
  output logic pd_wr_ok
);
  logic             busy;
  logic             pd_nxt, po_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             pd_en, po_en, cnt_en;

  assign busy     = grp_pd ^ grp_po;
  assign pd_wr_ok = !busy && !grp_pd;

  always_comb begin
    pd_nxt  = grp_pd;
    po_nxt  = grp_po;
    cnt_nxt = cnt;
    if (busy && grp_pd && wake_req) begin
      pd_nxt  = 1'b0;
      cnt_nxt = '0;
    end else if (busy) begin
      if (cnt == '0) po_nxt  = grp_pd;
      else           cnt_nxt = cnt - 1'b1;
    end else if (grp_pd && wake_req) begin
      pd_nxt  = 1'b0;
      cnt_nxt = CNT_W'(TRANS_CYCLES - 1);
    end else if (!grp_pd && sleep_req) begin
      pd_nxt  = 1'b1;
      cnt_nxt = CNT_W'(TRANS_CYCLES - 1);
    end
  end

  assign pd_en  = pd_nxt != grp_pd;
  assign po_en  = po_nxt != grp_po;
  assign cnt_en = cnt_nxt != cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_pd <= 1'b1;
      grp_po <= 1'b1;
      cnt    <= '0;
    end else begin
      if (pd_en)  grp_pd <= pd_nxt;
      if (po_en)  grp_po <= po_nxt;
      if (cnt_en) cnt    <= cnt_nxt;
    end
  end
endmodule

// File: rtl/rdgp_ctrl.sv
module rdgp_ctrl
  import rdgp_pkg::*;
#(
  parameter int unsigned NUM_FRAMES   = 4,
  parameter int unsigned OFS_W        = 16,
  parameter int unsigned TRANS_CYCLES = 6,
  localparam int unsigned FRAME_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int unsigned CNT_W       = $clog2(TRANS_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_en,
  input  logic                  acc_wr,
  input  logic [FRAME_W-1:0]    acc_frame,
  input  logic [OFS_W-1:0]      acc_offset,
  input  logic [31:0]           acc_wdata,
  output logic [31:0]           acc_rdata,
  output logic                  grp_off,
  output logic                  grp_busy,
  output logic [NUM_FRAMES-1:0] frame_on
);
  logic [NUM_FRAMES-1:0] wr_sel;
  pwr_wr_t               wr_fields;
  logic [NUM_FRAMES-1:0] frame_pd;
  logic [NUM_FRAMES-1:0] frame_gate;
  logic                  grp_pd, grp_po;
  logic                  pd_wr_ok;
  logic                  lone_off_req;
  logic                  wake_req;
  logic                  unused_wdata_hi;

  assign unused_wdata_hi = ^acc_wdata[31:2];

  rdgp_reg_decode #(
    .NUM_FRAMES(NUM_FRAMES), .FRAME_W(FRAME_W), .OFS_W(OFS_W)
  ) i_decode (
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_frame (acc_frame),
    .acc_offset(acc_offset),
    .acc_wbits (acc_wdata[1:0]),
    .frame_pd  (frame_pd),
    .frame_gate(frame_gate),
    .grp_pd    (grp_pd),
    .grp_po    (grp_po),
    .wr_sel    (wr_sel),
    .wr_fields (wr_fields),
    .acc_rdata (acc_rdata)
  );

  rdgp_frame_bank #(.NUM_FRAMES(NUM_FRAMES)) i_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_sel      (wr_sel),
    .wr_fields   (wr_fields),
    .pd_wr_ok    (pd_wr_ok),
    .frame_pd    (frame_pd),
    .frame_gate  (frame_gate),
    .lone_off_req(lone_off_req)
  );

  assign wake_req = (|wr_sel) && !wr_fields.pd;

  rdgp_group_seq #(.TRANS_CYCLES(TRANS_CYCLES), .CNT_W(CNT_W)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_req (wake_req),
    .sleep_req(lone_off_req),
    .grp_pd   (grp_pd),
    .grp_po   (grp_po),
    .pd_wr_ok (pd_wr_ok)
  );

  assign grp_off  = grp_pd & grp_po;
  assign grp_busy = grp_pd ^ grp_po;
  assign frame_on = ~frame_pd;
endmodule

// File: rtl/rdgp_ctrl_chk.sv
module rdgp_ctrl_chk
  import rdgp_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 4,
  parameter int unsigned FRAME_W    = 2,
  parameter int unsigned OFS_W      = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_en,
  input logic                  acc_wr,
  input logic [FRAME_W-1:0]    acc_frame,
  input logic [OFS_W-1:0]      acc_offset,
  input logic [31:0]           acc_wdata,
  input logic [31:0]           acc_rdata,
  input logic                  grp_busy,
  input logic [NUM_FRAMES-1:0] frame_pd,
  input logic                  grp_pd,
  input logic                  grp_po
);
  logic wake_wr;
  assign wake_wr = acc_en && acc_wr && !acc_wdata[0] && (int'(acc_frame) < NUM_FRAMES)
                   && (acc_offset == OFS_W'(PWR_REG_OFS));

  AST_RDATA_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rdata[31:4] == '0); // R3

  AST_PO_MOVES_IN_TRANSIT: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_po != $past(grp_po)) |-> $past(grp_pd != grp_po)); // R6

  AST_FRAMES_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(grp_busy) |-> (frame_pd == $past(frame_pd))); // R9

  AST_SHUTDOWN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(grp_pd && !grp_po && wake_wr) |-> (!grp_pd && !grp_po)); // R10

  AST_SHUTDOWN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_pd) |-> (&frame_pd)); // R8

  AST_FRAME_ON_GROUP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    !(&frame_pd) |-> !grp_pd); // R8
endmodule

bind rdgp_ctrl rdgp_ctrl_chk #(
  .NUM_FRAMES(NUM_FRAMES), .FRAME_W(FRAME_W), .OFS_W(OFS_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_wr    (acc_wr),
  .acc_frame (acc_frame),
  .acc_offset(acc_offset),
  .acc_wdata (acc_wdata),
  .acc_rdata (acc_rdata),
  .grp_busy  (grp_busy),
  .frame_pd  (frame_pd),
  .grp_pd    (grp_pd),
  .grp_po    (grp_po)
);

// File: tb/test_rdgp_ctrl.sv
`timescale 1ns/1ps
module test_rdgp_ctrl;
  localparam int NF = 4;
  localparam int OW = 16;
  localparam int TC = 6;
  localparam int FW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_en, acc_wr;
  logic [FW-1:0] acc_frame;
  logic [OW-1:0] acc_offset;
  logic [31:0]   acc_wdata, acc_rdata;
  logic          grp_off, grp_busy;
  logic [NF-1:0] frame_on;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rdgp_ctrl #(.NUM_FRAMES(NF), .OFS_W(OW), .TRANS_CYCLES(TC)) i_rdgp_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_frame(acc_frame), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .grp_off(grp_off), .grp_busy(grp_busy), .frame_on(frame_on)
  );

  // behavioural reference model
  bit m_pd[NF];
  bit m_gate[NF];
  bit m_req, m_obs;
  int m_wait;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pd[i]) begin m_pd[i] = 1'b1; m_gate[i] = 1'b0; end
      m_req = 1'b1; m_obs = 1'b1; m_wait = 0;
    end else begin
      bit busy, hit, wbit, lone;
      int f;
      busy = (m_req != m_obs);
      f    = int'(acc_frame);
      hit  = acc_en && acc_wr && acc_offset == 16'h0024 && f < NF;
      wbit = acc_wdata[0];
      if (hit) m_gate[f] = acc_wdata[1];
      if (busy) begin
        if (hit && m_req && !wbit) m_req = 1'b0;
        else if (m_wait == 0) m_obs = m_req;
        else m_wait--;
      end else if (hit) begin
        if (m_req) begin
          if (!wbit) begin m_req = 1'b0; m_wait = TC - 1; end
        end else begin
          lone = !m_pd[f];
          for (int i = 0; i < NF; i++) if (i != f && !m_pd[i]) lone = 1'b0;
          m_pd[f] = wbit;
          if (wbit && lone) begin m_req = 1'b1; m_wait = TC - 1; end
        end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic [NF-1:0] exp_on;
      logic [31:0]   exp_rd;
      for (int i = 0; i < NF; i++) exp_on[i] = !m_pd[i];
      chk("R11 grp_off", 32'(grp_off), 32'(m_req && m_obs));
      chk("R11 grp_busy", 32'(grp_busy), 32'(m_req != m_obs));
      chk("R11 frame_on", 32'(frame_on), 32'(exp_on));
      exp_rd = '0;
      if (acc_en && !acc_wr && acc_offset == 16'h0024 && int'(acc_frame) < NF)
        exp_rd = {28'b0, m_obs, m_req, m_gate[acc_frame], m_pd[acc_frame]};
      if (acc_en && !acc_wr) chk("R2 per-cycle read", acc_rdata, exp_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic rd(input int f, input logic [OW-1:0] off = 16'h0024);
    acc_en = 1'b1; acc_wr = 1'b0; acc_frame = FW'(f); acc_offset = off; acc_wdata = '0;
    #1;
  endtask

  task automatic wr(input int f, input logic [31:0] d, input logic [OW-1:0] off = 16'h0024);
    acc_en = 1'b1; acc_wr = 1'b1; acc_frame = FW'(f); acc_offset = off; acc_wdata = d;
    @(negedge clk); #2;
    rd(f);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; acc_frame = '0; acc_offset = '0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    rd(0);
    chk("R1 reset reg", acc_rdata, 32'h0000000D);
    chk("R1 reset grp_off", 32'(grp_off), 32'd1);
    chk("R1 reset frame_on", 32'(frame_on), 32'd0);
    // R2 other offset
    rd(0, 16'h0020);
    chk("R2 other offset", acc_rdata, 32'h0);
    // R3/R4 gating write with upper junk while group off
    wr(1, 32'hFFFF_FFF3);
    chk("R3 R4 gate set upper ignored", acc_rdata, 32'h0000000F);
    // R5 power-up request from off group
    wr(0, 32'h0);
    chk("R5 group wake reg", acc_rdata, 32'h00000009);
    chk("R5 busy", 32'(grp_busy), 32'd1);
    // R6 timing: one edge before due, then at due edge
    step(TC - 1);
    chk("R6 still busy before due", 32'(grp_busy), 32'd1);
    step(1);
    chk("R6 settled at due", acc_rdata, 32'h00000001);
    // R7 frame on in running group
    wr(0, 32'h0);
    chk("R7 frame0 on", acc_rdata, 32'h00000000);
    wr(1, 32'h0);
    chk("R7 two frames on", 32'(frame_on), 32'b0011);
    // R8 not last: group stays up
    wr(1, 32'h1);
    chk("R8 not last frame", acc_rdata, 32'h00000001);
    chk("R8 no transit", 32'(grp_busy), 32'd0);
    // R8 last frame off starts shutdown
    wr(0, 32'h1);
    chk("R8 last frame off", acc_rdata, 32'h00000005);
    // R10 abort, R9 frame bit not applied
    wr(2, 32'h0);
    chk("R10 R9 abort reg", acc_rdata, 32'h00000001);
    chk("R10 idle after abort", 32'(grp_busy), 32'd0);
    // full shutdown
    wr(3, 32'h0);
    wr(3, 32'h1);
    step(TC);
    chk("R8 group off after shutdown", 32'(grp_off), 32'd1);
    // R9 during power-up, R4 gating still applies
    wr(1, 32'h0);
    wr(2, 32'h2);
    chk("R9 R4 write in power-up", acc_rdata, 32'h0000000B);
    chk("R9 frame_on frozen", 32'(frame_on), 32'd0);
    step(TC);
    // R3 wrong offset write ignored
    wr(1, 32'h2, 16'h0028);
    chk("R3 wrong offset ignored", acc_rdata, 32'h00000001);
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule